// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable model of a small synchronous static RAM with a built-in two-bit burst address generator. All address, data and control inputs are sampled on the rising clock edge, except the output enable and the sleep input, which act at once without a register. A burst starts when either of two start strobes is seen while the chip is selected. That edge loads the external address into the burst register. The following addresses come from an internal two-bit counter that steps only in cycles where the advance input is high. A mode input, latched at burst start, picks linear or interleaved stepping through the low two address bits.

Read data is flow-through. The word at the registered address appears on the read port in the cycle that follows the loading edge, with no output register, so a four-beat burst reads in a 2-1-1-1 pattern. A write lands on the current registered address at the clock edge. It is either a per-lane write selected by a lane-enable plus lane picks, or a global write of all four lanes. The read port's drive enable controls an external tristate pad. While the sleep input is high, nothing changes: no address step, no load and no write.

Top module: `fsb_sram`

## Requirements
- R1: The chip counts as selected only when sel_a_n=0, sel_b=1 and sel_c_n=0 at a start edge. A start edge without selection makes the block inactive, and q_drive stays 0 until the next selected start.
- R2: A start edge, from either strb_host or strb_ctrl with the chip selected, loads addr into the burst register. From the next cycle, q shows that word with no extra latency.
- R3: After a load, the word address steps by one burst beat at each edge where step_en=1. With step_en=0 it holds. The two-bit beat count wraps after four beats.
- R4: With seq_linear=1 latched at the start edge, the low two address bits are (base + count) mod 4 and the upper bits stay at the base value.
- R5: With seq_linear=0 latched at the start edge, the low two address bits are base XOR count, and the upper bits are unchanged.
- R6: When lane_we=1 and full_we=0, only the lanes with lane_pick[i]=1 are written, where lane i is bits 8i+7..8i of the word. The other lanes keep their contents.
- R7: When full_we=1, all four lanes are written with wdata, whatever the values of lane_we and lane_pick.
- R8: Write controls in a cycle that also has a start edge have no effect, and neither does lane_we=1 with lane_pick=0. No write takes place while the block is inactive.
- R9: q_drive is 1 exactly when the block is active, out_en_n=0, doze=0 and no write control (full_we, or lane_we with any lane pick) is asserted in the current cycle. out_en_n and doze act within the same cycle.
- R10: While doze=1 at an edge, the burst address, the active state and the memory contents all stay unchanged.
- R11: A synchronous active-high rst leaves the block inactive with q_drive=0.
- R12: A new start may be issued on every cycle. Each loaded word is readable in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | External word address |
| wdata | input | 4*LANE_W | Write data, four lanes |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| strb_host | input | 1 | Burst start strobe, processor side |
| strb_ctrl | input | 1 | Burst start strobe, controller side |
| step_en | input | 1 | Advance the burst count |
| seq_linear | input | 1 | 1 = linear order, 0 = interleaved (tie low for the default) |
| lane_we | input | 1 | Lane write enable |
| lane_pick | input | 4 | Per-lane write select |
| full_we | input | 1 | Global write of every lane |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| doze | input | 1 | Asynchronous sleep, active high |
| q | output | 4*LANE_W | Flow-through read data |
| q_drive | output | 1 | Enable for the data pad's tristate driver |

## Verification
The bench builds the block with its default parameters: a six-bit address and eight-bit lanes, giving 64 words. At that size the whole array can be preloaded with known values in a few hundred cycles, so every read compares against a defined word. The small depth also puts bursts that wrap inside a four-word group at both ends of the array within reach, as well as every single-lane and mixed-lane write pattern.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

    localparam int LANES = 4;
    localparam int BEAT_W = 2;

    typedef struct packed {
        logic              active;
        logic              linear;
        logic [BEAT_W-1:0] beat;
    } burst_ctl_t;

    // Low address bits for a given beat of a burst
    function automatic logic [BEAT_W-1:0] beat_low(
        input logic [BEAT_W-1:0] base_low,
        input logic [BEAT_W-1:0] beat,
        input logic              linear
    );
        return linear ? (base_low + beat) : (base_low ^ beat);
    endfunction

endpackage

// File: rtl/fsb_addr_gen.sv
module fsb_addr_gen
    import fsb_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          load,
    input  logic          selected,
    input  logic          step,
    input  logic          linear_in,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] cur_addr,
    output burst_ctl_t    ctl
);

    logic [AW-1:0] base_q;
    burst_ctl_t    ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ctl_q  <= '0;
        end else if (!hold) begin
            if (load) begin
                base_q       <= addr_in;
                ctl_q.active <= selected;
                ctl_q.linear <= linear_in;
                ctl_q.beat   <= '0;
            end else if (step && ctl_q.active) begin
                ctl_q.beat <= ctl_q.beat + 1'b1;
            end
        end
    end

    assign cur_addr = {base_q[AW-1:BEAT_W],
                       beat_low(base_q[BEAT_W-1:0], ctl_q.beat, ctl_q.linear)};
    assign ctl = ctl_q;

endmodule

// File: rtl/fsb_wr_dec.sv
module fsb_wr_dec
    import fsb_pkg::*;
(
    input  logic             full_we,
    input  logic             lane_we,
    input  logic [LANES-1:0] lane_pick,
    input  logic             active,
    input  logic             start,
    input  logic             hold,
    output logic [LANES-1:0] mask,
    output logic             wr_req
);

    logic allow;

    assign wr_req = full_we || (lane_we && (|lane_pick));
    assign allow  = active && !start && !hold;

    always_comb begin
        mask = '0;
        if (allow) begin
            if (full_we)      mask = '1;
            else if (lane_we) mask = lane_pick;
        end
    end

endmodule

// File: rtl/fsb_lane_mem.sv
module fsb_lane_mem
    import fsb_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        mask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (mask[l]) store[addr] <= wdata[l*LANE_W +: LANE_W];
        end

        assign rdata[l*LANE_W +: LANE_W] = store[addr];
    end

endmodule

// File: rtl/fsb_sram.sv
module fsb_sram
    import fsb_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [AW-1:0]           addr,
    input  logic [4*LANE_W-1:0]     wdata,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    strb_host,
    input  logic                    strb_ctrl,
    input  logic                    step_en,
    input  logic                    seq_linear,
    input  logic                    lane_we,
    input  logic [3:0]              lane_pick,
    input  logic                    full_we,
    input  logic                    out_en_n,
    input  logic                    doze,
    output logic [4*LANE_W-1:0]     q,
    output logic                    q_drive
);

    logic             sel_now;
    logic             start;
    logic [AW-1:0]    eff_addr;
    burst_ctl_t       ctl;
    logic [LANES-1:0] wr_mask;
    logic             wr_req;

    assign sel_now = !sel_a_n && sel_b && !sel_c_n;
    assign start   = strb_host || strb_ctrl;

    fsb_addr_gen #(.AW(AW)) u_gen (
        .clk       (clk),
        .rst       (rst),
        .hold      (doze),
        .load      (start),
        .selected  (sel_now),
        .step      (step_en),
        .linear_in (seq_linear),
        .addr_in   (addr),
        .cur_addr  (eff_addr),
        .ctl       (ctl)
    );

    fsb_wr_dec u_dec (
        .full_we   (full_we),
        .lane_we   (lane_we),
        .lane_pick (lane_pick),
        .active    (ctl.active),
        .start     (start),
        .hold      (doze),
        .mask      (wr_mask),
        .wr_req    (wr_req)
    );

    fsb_lane_mem #(.AW(AW), .LANE_W(LANE_W)) u_mem (
        .clk   (clk),
        .addr  (eff_addr),
        .mask  (wr_mask),
        .wdata (wdata),
        .rdata (q)
    );

    assign q_drive = ctl.active && !out_en_n && !doze && !wr_req;

endmodule

// File: rtl/fsb_sram_chk.sv
module fsb_sram_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          doze,
    input logic          out_en_n,
    input logic          q_drive,
    input logic          start,
    input logic          sel_now,
    input logic          step_en,
    input logic          full_we,
    input logic [AW-1:0] addr,
    input logic [AW-1:0] eff_addr,
    input logic          active,
    input logic [1:0]    beat,
    input logic [3:0]    wr_mask
);

    // R9
    drive_gate_chk: assert property (@(posedge clk) disable iff (rst)
        q_drive |-> (!out_en_n && !doze && active));

    // R10
    doze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        doze |=> ($stable(eff_addr) && $stable(active)));

    // R2
    load_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (start && sel_now && !doze) |=> (active && eff_addr == $past(addr)));

    // R1
    desel_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !sel_now && !doze) |=> !active);

    // R3
    beat_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && step_en && active && !doze) |=> (beat == $past(beat) + 2'd1));

    // R3
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && !step_en && !doze) |=> $stable(eff_addr));

    // R7
    full_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (full_we && active && !start && !doze) |-> (wr_mask == 4'hF));

    // R8
    start_nowr_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> (wr_mask == 4'h0));

endmodule

bind fsb_sram fsb_sram_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .doze     (doze),
    .out_en_n (out_en_n),
    .q_drive  (q_drive),
    .start    (start),
    .sel_now  (sel_now),
    .step_en  (step_en),
    .full_we  (full_we),
    .addr     (addr),
    .eff_addr (eff_addr),
    .active   (ctl.active),
    .beat     (ctl.beat),
    .wr_mask  (wr_mask)
);

// File: tb/fsb_sram_bench.sv
`timescale 1ns/1ps
module fsb_sram_bench;

    localparam int AW = 6;
    localparam int LW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic          sel_a_n, sel_b, sel_c_n;
    logic          strb_host, strb_ctrl, step_en, seq_linear;
    logic          lane_we, full_we, out_en_n, doze;
    logic [3:0]    lane_pick;
    logic [31:0]   q;
    logic          q_drive;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [31:0] m_mem [DEPTH];
    int          m_base, m_cnt;
    bit          m_lin, m_act;

    always #4 clk = ~clk;

    fsb_sram #(.AW(AW), .LANE_W(LW)) u_fsb_sram (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .strb_host(strb_host), .strb_ctrl(strb_ctrl), .step_en(step_en),
        .seq_linear(seq_linear), .lane_we(lane_we), .lane_pick(lane_pick),
        .full_we(full_we), .out_en_n(out_en_n), .doze(doze),
        .q(q), .q_drive(q_drive)
    );

    function automatic int m_addr();
        int lo;
        lo = m_lin ? ((m_base + m_cnt) & 3) : ((m_base ^ m_cnt) & 3);
        return (m_base & ~3) | lo;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        strb_host = 0; strb_ctrl = 0; step_en = 0;
        lane_we = 0; full_we = 0; lane_pick = 4'h0;
        sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    endtask

    // Called just after a falling edge with inputs already set.
    task automatic step(string tag);
        bit wr, exp_drv, st, sel;
        int a;
        #1;
        wr = full_we || (lane_we && (lane_pick != 0));
        exp_drv = m_act && !out_en_n && !doze && !wr;
        chk(tag, "drive", {31'd0, q_drive}, {31'd0, exp_drv});
        if (exp_drv) chk(tag, "data", q, m_mem[m_addr()]);
        @(posedge clk);
        if (rst) begin
            m_act = 0; m_base = 0; m_cnt = 0; m_lin = 0;
        end else if (!doze) begin
            st  = strb_host || strb_ctrl;
            sel = !sel_a_n && sel_b && !sel_c_n;
            if (m_act && !st) begin
                a = m_addr();
                for (int l = 0; l < 4; l++)
                    if (full_we || (lane_we && lane_pick[l]))
                        m_mem[a][l*8 +: 8] = wdata[l*8 +: 8];
            end
            if (st) begin
                m_act = sel; m_base = int'(addr); m_cnt = 0; m_lin = seq_linear;
            end else if (step_en && m_act) begin
                m_cnt = (m_cnt + 1) % 4;
            end
        end
        @(negedge clk);
    endtask

    task automatic load(string tag, int a, bit lin, bit which);
        idle();
        addr = AW'(a); seq_linear = lin;
        if (which) strb_ctrl = 1; else strb_host = 1;
        step(tag);
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 32'h0;
        m_act = 0; m_base = 0; m_cnt = 0; m_lin = 0;
        idle(); addr = '0; wdata = '0; seq_linear = 0;
        out_en_n = 0; doze = 0; rst = 1;
        @(negedge clk);
        // R11: reset leaves the output undriven
        step("R11"); step("R11");
        rst = 0;
        step("R11");

        // R7: preload every word with a global write, lane controls noisy
        for (int i = 0; i < DEPTH; i++) begin
            load("R7", i, 0, i[0]);
            full_we = 1; lane_we = i[1]; lane_pick = 4'(i);
            wdata = 32'h9E3779B1 * (i + 1);
            step("R7");
            idle();
        end

        // R2 / R12: new address every cycle, either strobe
        for (int i = 0; i < 12; i++) load("R12", (i * 7) % DEPTH, 0, i[0]);
        step("R2");

        // R4: linear bursts from each low-bit phase, wrapping
        for (int b = 60; b < 64; b++) begin
            load("R4", b, 1, 0);
            for (int k = 0; k < 5; k++) begin step_en = 1; step("R4"); end
            idle();
        end

        // R5: interleaved bursts
        for (int b = 0; b < 4; b++) begin
            load("R5", 20 + b, 0, 1);
            for (int k = 0; k < 5; k++) begin step_en = 1; step("R5"); end
            idle();
        end

        // R3: hold without step, then step
        load("R3", 33, 1, 0);
        step("R3"); step("R3"); step("R3");
        step_en = 1; step("R3"); step_en = 0; step("R3"); step("R3");

        // R6: lane writes with several patterns, then read back
        for (int p = 1; p < 16; p++) begin
            load("R6", 40 + (p % 4), 0, 0);
            lane_we = 1; lane_pick = 4'(p); wdata = 32'hC0DE0000 + 32'(p * 32'h1111);
            step("R6");
            idle(); step("R6");
        end

        // R8: write in a start cycle, and lane_we with no lanes
        load("R8", 12, 0, 0);
        strb_host = 1; addr = 6'd13; full_we = 1; wdata = 32'hDEADBEEF;
        step("R8");
        idle(); step("R8");
        lane_we = 1; lane_pick = 4'h0; wdata = 32'hFFFFFFFF; step("R8");
        idle(); step("R8");
        load("R8", 12, 0, 0); step("R8");

        // R1: deselect combinations on a start
        for (int c = 0; c < 8; c++) begin
            idle(); addr = 6'd3; strb_ctrl = 1;
            sel_a_n = c[0]; sel_b = ~c[1]; sel_c_n = c[2];
            step("R1");
            idle(); step("R1");
            full_we = 1; wdata = 32'h12345678; step("R1");
            idle(); step("R1");
        end
        load("R1", 3, 0, 0); step("R1");

        // R9: output enable and write gating within the cycle
        out_en_n = 1; step("R9");
        out_en_n = 0; step("R9");
        lane_we = 1; lane_pick = 4'h4; wdata = 32'h00AB0000; step("R9");
        idle(); step("R9");

        // R10: doze freezes everything
        load("R10", 50, 1, 0);
        doze = 1;
        strb_host = 1; addr = 6'd7; step("R10");
        idle(); step_en = 1; step("R10");
        full_we = 1; wdata = 32'h55555555; step("R10");
        idle();
        doze = 0; step("R10");
        step_en = 1; step("R10");
        idle(); step("R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule